// File: doc/BRIEF.md
# Dual Serial Flash Connection Router

This block sits between one quad serial flash controller engine and two identical serial flash devices, called the lower and the upper device. It takes the controller's single chip select, serial clock and data lines and routes them to the devices in one of three connection modes. A three-bit control field sets the mode.

In single mode only the lower device is used and the controller bus passes straight through. In stacked mode both devices hang on one shared clock and data bus. The block steers the chip select to one of them, chosen by a page bit. In parallel mode each device has its own bus and both are selected together. During the data phase each 8-bit controller beat is split by bit position: even bits go to the lower device and odd bits to the upper device. Read beats are merged back the same way. Outside the data phase, the command and address nibble is copied onto both buses.

The mode is taken from the control field only while the controller chip select is inactive. A change requested during a transfer therefore waits for the end of that transfer.

Top module: `dual_flash_router`

## Requirements
- R1: After reset, and before the control field has been sampled, the block acts in single mode. Only the lower device can be selected, and up_cs_no stays 1.
- R2: In single mode (mem_cfg_i[2]=0), the lower bus carries ctrl_dq_i[3:0], ctrl_dq_oe_i[3:0], ctrl_sclk_i and ctrl_cs_ni unchanged. The upper device has chip select 1, output enables 0 and clock 0. ctrl_dq_o equals {4'b0, lo_dq_i}.
- R3: In stacked mode (mem_cfg_i[2:1]=2'b10) with the page bit mem_cfg_i[0]=0, the lower device gets the chip select and data. The upper device has chip select 1 and output enables 0, and both clocks follow ctrl_sclk_i. Reads return {4'b0, lo_dq_i}.
- R4: In stacked mode with mem_cfg_i[0]=1, the upper device gets the chip select, data and output enables. The lower device has chip select 1 and output enables 0. Reads return {4'b0, up_dq_i}.
- R5: In parallel mode (mem_cfg_i[2:1]=2'b11), both device chip selects equal ctrl_cs_ni in the same cycle, and both clocks follow ctrl_sclk_i.
- R6: In parallel mode with ctrl_data_phase_i=1, lane k of the lower bus carries ctrl_dq_i[2k] and its enable ctrl_dq_oe_i[2k]. Lane k of the upper bus carries ctrl_dq_i[2k+1] and ctrl_dq_oe_i[2k+1].
- R7: In parallel mode with ctrl_data_phase_i=1, ctrl_dq_o[2k] equals lo_dq_i[k] and ctrl_dq_o[2k+1] equals up_dq_i[k].
- R8: In parallel mode with ctrl_data_phase_i=0, both buses carry ctrl_dq_i[3:0] with enables ctrl_dq_oe_i[3:0], and ctrl_dq_o equals {4'b0, lo_dq_i}.
- R9: The control field is captured at each rising clk_i edge at which ctrl_cs_ni is 1, and at no other edge. A change made while ctrl_cs_ni is 0, including one that arrives together with the falling chip select, has no effect until that capture.
- R10: While ctrl_cs_ni is 1, both lo_cs_no and up_cs_no are 1 in every mode.
- R11: When mem_cfg_i[2]=0, the separate-bus bit and the page bit have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the control field |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_cfg_i | input | 3 | Control field: [2] two-device enable, [1] separate-bus enable, [0] upper page |
| ctrl_sclk_i | input | 1 | Serial clock from the controller |
| ctrl_cs_ni | input | 1 | Controller chip select, active low |
| ctrl_data_phase_i | input | 1 | High while the controller is in the data phase |
| ctrl_dq_i | input | 8 | Controller output beat (only [3:0] used outside parallel data phase) |
| ctrl_dq_oe_i | input | 8 | Per-bit output enables of the controller beat |
| ctrl_dq_o | output | 8 | Read beat returned to the controller |
| lo_sclk_o | output | 1 | Lower device clock |
| lo_cs_no | output | 1 | Lower device chip select, active low |
| lo_dq_o | output | 4 | Lower device data out |
| lo_dq_oe_o | output | 4 | Lower device data output enables |
| lo_dq_i | input | 4 | Lower device data in |
| up_sclk_o | output | 1 | Upper device clock |
| up_cs_no | output | 1 | Upper device chip select, active low |
| up_dq_o | output | 4 | Upper device data out |
| up_dq_oe_o | output | 4 | Upper device data output enables |
| up_dq_i | input | 4 | Upper device data in |

## Verification
The case that needs care is a mode change and a chip select edge arriving in the same cycle. The bench moves ctrl_cs_ni low in the same drive that changes the control field, and then checks that the whole transfer still follows the old mode. It also raises the chip select together with a new field, and checks that the next transfer follows the new mode. The random phase mixes field changes, idle cycles and data and command beats, so both orderings come up many times. Each beat is compared against a model whose mode register captures the field only at edges where the chip select was high.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'd0,
    MODE_STACKED  = 2'd1,
    MODE_PARALLEL = 2'd2
  } conn_mode_e;

  // field: [2] two devices, [1] separate buses, [0] upper page
  function automatic conn_mode_e decode_mode(input logic [2:0] cfg);
    if (!cfg[2])     return MODE_SINGLE;
    else if (cfg[1]) return MODE_PARALLEL;
    else             return MODE_STACKED;
  endfunction
endpackage

// File: rtl/dfr_cfg_latch.sv
module dfr_cfg_latch
  import dfr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mem_cfg_i,
  input  logic       idle_i,
  output conn_mode_e mode_o,
  output logic       upage_o
);
  conn_mode_e mode_q;
  logic       upage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_SINGLE;
      upage_q <= 1'b0;
    end else if (idle_i) begin
      mode_q  <= decode_mode(mem_cfg_i);
      upage_q <= mem_cfg_i[2] & mem_cfg_i[0];
    end
  end

  assign mode_o  = mode_q;
  assign upage_o = upage_q;
endmodule

// File: rtl/dfr_sel.sv
module dfr_sel
  import dfr_pkg::*;
(
  input  conn_mode_e mode_i,
  input  logic       upage_i,
  input  logic       ctrl_cs_ni,
  input  logic       ctrl_sclk_i,
  output logic       lo_en_o,
  output logic       up_en_o,
  output logic       lo_cs_no,
  output logic       up_cs_no,
  output logic       lo_sclk_o,
  output logic       up_sclk_o
);
  always_comb begin
    unique case (mode_i)
      MODE_STACKED: begin
        lo_en_o = ~upage_i;
        up_en_o = upage_i;
      end
      MODE_PARALLEL: begin
        lo_en_o = 1'b1;
        up_en_o = 1'b1;
      end
      default: begin
        lo_en_o = 1'b1;
        up_en_o = 1'b0;
      end
    endcase
  end

  assign lo_cs_no  = ctrl_cs_ni | ~lo_en_o;
  assign up_cs_no  = ctrl_cs_ni | ~up_en_o;
  assign lo_sclk_o = ctrl_sclk_i;
  // shared clock in stacked mode, own clock in parallel mode
  assign up_sclk_o = ctrl_sclk_i & (mode_i != MODE_SINGLE);
endmodule

// File: rtl/dfr_tx_split.sv
module dfr_tx_split
  import dfr_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned CW   = 2 * LANES
) (
  input  conn_mode_e       mode_i,
  input  logic             data_phase_i,
  input  logic             lo_en_i,
  input  logic             up_en_i,
  input  logic [CW-1:0]    dq_i,
  input  logic [CW-1:0]    oe_i,
  output logic [LANES-1:0] lo_dq_o,
  output logic [LANES-1:0] lo_oe_o,
  output logic [LANES-1:0] up_dq_o,
  output logic [LANES-1:0] up_oe_o
);
  logic split;
  assign split = (mode_i == MODE_PARALLEL) & data_phase_i;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lo_dq_o[k] = split ? dq_i[2*k]   : dq_i[k];
    assign up_dq_o[k] = split ? dq_i[2*k+1] : dq_i[k];
    assign lo_oe_o[k] = lo_en_i & (split ? oe_i[2*k]   : oe_i[k]);
    assign up_oe_o[k] = up_en_i & (split ? oe_i[2*k+1] : oe_i[k]);
  end
endmodule

// File: rtl/dfr_rx_merge.sv
module dfr_rx_merge
  import dfr_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned CW   = 2 * LANES
) (
  input  conn_mode_e       mode_i,
  input  logic             data_phase_i,
  input  logic             upage_i,
  input  logic [LANES-1:0] lo_dq_i,
  input  logic [LANES-1:0] up_dq_i,
  output logic [CW-1:0]    dq_o
);
  logic             split;
  logic [LANES-1:0] src;

  assign split = (mode_i == MODE_PARALLEL) & data_phase_i;
  assign src   = (mode_i == MODE_STACKED && upage_i) ? up_dq_i : lo_dq_i;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign dq_o[2*k]   = split ? lo_dq_i[k] : ((2*k   < LANES) ? src[(2*k)   % LANES] : 1'b0);
    assign dq_o[2*k+1] = split ? up_dq_i[k] : ((2*k+1 < LANES) ? src[(2*k+1) % LANES] : 1'b0);
  end
endmodule

// File: rtl/dual_flash_router.sv
module dual_flash_router
  import dfr_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned CW   = 2 * LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mem_cfg_i,
  input  logic             ctrl_sclk_i,
  input  logic             ctrl_cs_ni,
  input  logic             ctrl_data_phase_i,
  input  logic [CW-1:0]    ctrl_dq_i,
  input  logic [CW-1:0]    ctrl_dq_oe_i,
  output logic [CW-1:0]    ctrl_dq_o,
  output logic             lo_sclk_o,
  output logic             lo_cs_no,
  output logic [LANES-1:0] lo_dq_o,
  output logic [LANES-1:0] lo_dq_oe_o,
  input  logic [LANES-1:0] lo_dq_i,
  output logic             up_sclk_o,
  output logic             up_cs_no,
  output logic [LANES-1:0] up_dq_o,
  output logic [LANES-1:0] up_dq_oe_o,
  input  logic [LANES-1:0] up_dq_i
);
  conn_mode_e mode_q;
  logic       upage_q;
  logic       lo_en, up_en;

  dfr_cfg_latch u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mem_cfg_i(mem_cfg_i),
    .idle_i   (ctrl_cs_ni),
    .mode_o   (mode_q),
    .upage_o  (upage_q)
  );

  dfr_sel u_sel (
    .mode_i     (mode_q),
    .upage_i    (upage_q),
    .ctrl_cs_ni (ctrl_cs_ni),
    .ctrl_sclk_i(ctrl_sclk_i),
    .lo_en_o    (lo_en),
    .up_en_o    (up_en),
    .lo_cs_no   (lo_cs_no),
    .up_cs_no   (up_cs_no),
    .lo_sclk_o  (lo_sclk_o),
    .up_sclk_o  (up_sclk_o)
  );

  dfr_tx_split #(.LANES(LANES)) u_tx (
    .mode_i      (mode_q),
    .data_phase_i(ctrl_data_phase_i),
    .lo_en_i     (lo_en),
    .up_en_i     (up_en),
    .dq_i        (ctrl_dq_i),
    .oe_i        (ctrl_dq_oe_i),
    .lo_dq_o     (lo_dq_o),
    .lo_oe_o     (lo_dq_oe_o),
    .up_dq_o     (up_dq_o),
    .up_oe_o     (up_dq_oe_o)
  );

  dfr_rx_merge #(.LANES(LANES)) u_rx (
    .mode_i      (mode_q),
    .data_phase_i(ctrl_data_phase_i),
    .upage_i     (upage_q),
    .lo_dq_i     (lo_dq_i),
    .up_dq_i     (up_dq_i),
    .dq_o        (ctrl_dq_o)
  );
endmodule

// File: rtl/dfr_chk.sv
module dfr_chk
  import dfr_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_cs_ni,
  input conn_mode_e       mode_i,
  input logic             lo_cs_no,
  input logic             up_cs_no,
  input logic             up_sclk_o,
  input logic [LANES-1:0] lo_dq_oe_o,
  input logic [LANES-1:0] up_dq_oe_o
);
  // R10
  idle_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_cs_ni |-> (lo_cs_no && up_cs_no));

  // R5
  par_cs_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PARALLEL) |-> (lo_cs_no == up_cs_no));

  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!ctrl_cs_ni) |-> $stable(mode_i));

  // R3
  stacked_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STACKED) |->
      ((lo_cs_no || up_cs_no) && (lo_dq_oe_o == '0 || up_dq_oe_o == '0)));

  // R2
  single_up_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SINGLE) |-> (up_cs_no && up_dq_oe_o == '0 && !up_sclk_o));
endmodule

bind dual_flash_router dfr_chk #(.LANES(LANES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctrl_cs_ni(ctrl_cs_ni),
  .mode_i    (mode_q),
  .lo_cs_no  (lo_cs_no),
  .up_cs_no  (up_cs_no),
  .up_sclk_o (up_sclk_o),
  .lo_dq_oe_o(lo_dq_oe_o),
  .up_dq_oe_o(up_dq_oe_o)
);

// File: tb/dual_flash_router_tb_top.sv
module dual_flash_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mem_cfg = 3'b000;
  logic sclk = 1'b0, cs_n = 1'b1, phase = 1'b0;
  logic [CW-1:0] dq = '0, oe = '0, rd;
  logic lo_sclk, lo_cs_n, up_sclk, up_cs_n;
  logic [LANES-1:0] lo_dq, lo_oe, up_dq, up_oe;
  logic [LANES-1:0] lo_in = '0, up_in = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model state: 0 single, 1 stacked, 2 parallel
  int   m_mode;
  logic m_page;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_flash_router #(.LANES(LANES)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mem_cfg_i(mem_cfg),
    .ctrl_sclk_i(sclk), .ctrl_cs_ni(cs_n), .ctrl_data_phase_i(phase),
    .ctrl_dq_i(dq), .ctrl_dq_oe_i(oe), .ctrl_dq_o(rd),
    .lo_sclk_o(lo_sclk), .lo_cs_no(lo_cs_n), .lo_dq_o(lo_dq), .lo_dq_oe_o(lo_oe), .lo_dq_i(lo_in),
    .up_sclk_o(up_sclk), .up_cs_no(up_cs_n), .up_dq_o(up_dq), .up_dq_oe_o(up_oe), .up_dq_i(up_in)
  );

  // R9 model: capture only at edges that see chip select high
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 0;
      m_page <= 1'b0;
    end else if (cs_n) begin
      m_mode <= !mem_cfg[2] ? 0 : (mem_cfg[1] ? 2 : 1);
      m_page <= mem_cfg[2] & mem_cfg[0];
    end
  end

  function automatic logic [27:0] expect_vec();
    logic lo_en, up_en, split;
    logic [LANES-1:0] e_lo, e_lo_oe, e_up, e_up_oe, src;
    logic [CW-1:0] e_rd;
    lo_en = (m_mode == 1) ? ~m_page : 1'b1;
    up_en = (m_mode == 0) ? 1'b0 : ((m_mode == 1) ? m_page : 1'b1);
    split = (m_mode == 2) && phase;
    src = (m_mode == 1 && m_page) ? up_in : lo_in;
    e_rd = {4'b0, src};
    for (int k = 0; k < LANES; k++) begin
      e_lo[k]    = split ? dq[2*k]   : dq[k];
      e_up[k]    = split ? dq[2*k+1] : dq[k];
      e_lo_oe[k] = lo_en & (split ? oe[2*k]   : oe[k]);
      e_up_oe[k] = up_en & (split ? oe[2*k+1] : oe[k]);
      if (split) begin
        e_rd[2*k]   = lo_in[k];
        e_rd[2*k+1] = up_in[k];
      end
    end
    return {cs_n | ~lo_en, cs_n | ~up_en, sclk, sclk & (m_mode != 0),
            e_lo, e_lo_oe, e_up, e_up_oe, e_rd};
  endfunction

  task automatic check_all(input string req);
    logic [27:0] act, exp;
    act = {lo_cs_n, up_cs_n, lo_sclk, up_sclk, lo_dq, lo_oe, up_dq, up_oe, rd};
    exp = expect_vec();
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s outputs actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_eq(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic beat(input logic c, input logic s, input logic ph, input logic [CW-1:0] d,
                      input logic [CW-1:0] e, input logic [3:0] li, input logic [3:0] ui,
                      input logic [2:0] cfg);
    @(negedge clk);
    cs_n = c; sclk = s; phase = ph; dq = d; oe = e; lo_in = li; up_in = ui; mem_cfg = cfg;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset with chip select low and a parallel field pending
    cs_n = 1'b0; mem_cfg = 3'b110;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    beat(1'b0, 1'b1, 1'b1, 8'hA5, 8'hFF, 4'h3, 4'hC, 3'b110);
    expect_eq("R1", "lo_cs", {7'b0, lo_cs_n}, 8'h00);
    expect_eq("R1", "up_cs", {7'b0, up_cs_n}, 8'h01);
    check_all("R1");

    // R11/R2: single mode with the other bits set
    beat(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 4'h0, 4'h0, 3'b011);
    expect_eq("R10", "cs pair", {6'b0, lo_cs_n, up_cs_n}, 8'h03);
    beat(1'b0, 1'b1, 1'b1, 8'h5C, 8'h0F, 4'h9, 4'h6, 3'b011);
    expect_eq("R2", "lo_dq", {4'b0, lo_dq}, 8'h0C);
    expect_eq("R11", "up_oe", {4'b0, up_oe}, 8'h00);
    expect_eq("R2", "read", rd, 8'h09);
    check_all("R2");

    // R3: stacked, lower page
    beat(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 4'h0, 4'h0, 3'b100);
    beat(1'b0, 1'b1, 1'b0, 8'h0B, 8'h0F, 4'h2, 4'hD, 3'b100);
    expect_eq("R3", "cs", {6'b0, lo_cs_n, up_cs_n}, 8'h01);
    expect_eq("R3", "up_sclk", {7'b0, up_sclk}, 8'h01);
    expect_eq("R3", "read", rd, 8'h02);
    check_all("R3");

    // R4: stacked, upper page
    beat(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 4'h0, 4'h0, 3'b101);
    beat(1'b0, 1'b0, 1'b1, 8'h07, 8'h0F, 4'h2, 4'hD, 3'b101);
    expect_eq("R4", "cs", {6'b0, lo_cs_n, up_cs_n}, 8'h02);
    expect_eq("R4", "up_dq", {4'b0, up_dq}, 8'h07);
    expect_eq("R4", "lo_oe", {4'b0, lo_oe}, 8'h00);
    expect_eq("R4", "read", rd, 8'h0D);

    // parallel: R8 command phase, then R6/R7 data phase
    beat(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 4'h0, 4'h0, 3'b110);
    beat(1'b0, 1'b1, 1'b0, 8'hE6, 8'h0F, 4'hA, 4'h5, 3'b110);
    expect_eq("R5", "cs", {6'b0, lo_cs_n, up_cs_n}, 8'h00);
    expect_eq("R8", "buses", {lo_dq, up_dq}, 8'h66);
    expect_eq("R8", "read", rd, 8'h0A);
    beat(1'b0, 1'b0, 1'b1, 8'hAA, 8'h5A, 4'hF, 4'h0, 3'b110);
    expect_eq("R6", "lo_dq", {4'b0, lo_dq}, 8'h00);
    expect_eq("R6", "up_dq", {4'b0, up_dq}, 8'h0F);
    expect_eq("R6", "oe", {lo_oe, up_oe}, 8'hC3);
    expect_eq("R7", "read", rd, 8'h55);
    beat(1'b0, 1'b1, 1'b1, 8'h3C, 8'hFF, 4'h6, 4'h9, 3'b110);
    expect_eq("R7", "read2", rd, 8'h96);
    check_all("R6");

    // R9: change mid-transfer waits for deassert
    beat(1'b0, 1'b0, 1'b0, 8'h01, 8'h0F, 4'h0, 4'h0, 3'b101);
    expect_eq("R9", "mid cs", {6'b0, lo_cs_n, up_cs_n}, 8'h00);
    beat(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 4'h0, 4'h0, 3'b101);
    beat(1'b0, 1'b0, 1'b0, 8'h01, 8'h0F, 4'h0, 4'h0, 3'b101);
    expect_eq("R9", "after cs", {6'b0, lo_cs_n, up_cs_n}, 8'h02);
    // R9: field changes on the same drive as the falling chip select
    beat(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 4'h0, 4'h0, 3'b101);
    beat(1'b0, 1'b0, 1'b0, 8'h01, 8'h0F, 4'h0, 4'h0, 3'b000);
    expect_eq("R9", "same edge", {6'b0, lo_cs_n, up_cs_n}, 8'h02);
    check_all("R9");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic c;
      logic [2:0] f;
      c = ($urandom % 4) == 0;
      f = (($urandom % 6) == 0) ? 3'($urandom) : mem_cfg;
      beat(c, 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
           4'($urandom), 4'($urandom), f);
      check_all("R5/R6/R7/R8/R9/R10");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule